// File: doc/BRIEF.md
# Horizontal Sample Rate Converter

This block resamples one video line of 8-bit luminance samples to a new horizontal sample count. A phase accumulator advances by a programmable step for every output sample. Its integer part says which two neighbouring input samples the output falls between, and its 8-bit fraction weights a linear interpolation between them. Depending on the step, the line is stretched by up to a factor 2 or shrunk down to half its length. The step code is a 9-bit value with 384 usable increments across that range.

Everything runs on one clock. Input samples arrive at half that rate: the block drives an `in_slot` strobe that is high on every second cycle, and input is sampled only on slot cycles. Output samples can leave on every cycle. A cycle that carries no output sample is marked by a low `out_we`, so there is never a separate output clock. A small internal FIFO holds accepted input samples until the interpolator uses them.

A line begins when the input write enable is seen high on a slot cycle after being low. That sample is the first sample of the line. The line ends after a programmed number of output samples. The controller has three states:
- IDLE: waiting for a line start.
- PRIME: loading the first two input samples into the interpolation window.
- RUN: producing output samples.

Transitions: a line start moves IDLE, PRIME or RUN to PRIME (or to IDLE when the count is zero). PRIME moves to RUN after its second load. RUN moves to IDLE on the output that reaches the count.

Top module: `hsrc_resampler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_we` and `out_data` are 0.
- R2: A step code c advances the read position by (128 + min(c, 384))/256 input samples per output sample. Code 0 is a factor-2 zoom and code 384 a factor-2 compress. Any code above 384 behaves exactly as 384.
- R3: Output sample k of a line has position p = k*inc, with i = p/256 and f = p mod 256. Its value is s[i] + floor(((s[i+1] - s[i])*f + 128)/256), clamped to 0..255, where s[n] is the n-th input sample of the line.
- R4: `out_we` is high for exactly one cycle per produced output sample and is low on every other cycle, including all cycles outside a line.
- R5: A line start is a slot cycle with `in_we` high whose previous slot cycle had `in_we` low. It discards any buffered samples, abandons a line still in progress, and takes that cycle's `in_data` as s[0].
- R6: A line produces exactly `out_count` outputs and then ignores further input until the next line start. An `out_count` of 0 produces no output.
- R7: `in_slot` is 0 in the first cycle after reset and then toggles on every clock. `in_we` and `in_data` are sampled only in cycles where `in_slot` is 1.
- R8: With step code 0 and input samples on every slot, the first output of a line is followed by outputs on every consecutive cycle until the count is reached.
- R9: With step code 384 and input on every slot, every output of the line is produced without the internal buffer overflowing or being read while empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; output rate, twice the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Input write enable; sampled on slot cycles |
| in_data | input | 8 | Input luminance sample |
| step_code | input | 9 | Conversion step code, 0 to 384 used |
| out_count | input | 11 | Number of output samples per line |
| in_slot | output | 1 | High on cycles where input is sampled |
| out_we | output | 1 | Output write enable; high when out_data is a new sample |
| out_data | output | 8 | Output luminance sample |

## Verification
The assertions take for granted that `step_code` and `out_count` stay constant from a line start until its last output. They also assume an input line delivers one sample per slot cycle, since the buffer's bound on occupancy depends on that arrival rate. The stimulus changes the step and count only between lines. It drives `in_we` and `in_data` at falling edges of cycles in which `in_slot` is 1, with no gaps inside a line and at least one low slot before each new line.

// File: rtl/hsrc_pkg.sv
package hsrc_pkg;

    // Controller states of the resampler.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } hsrc_state_e;

endpackage

// File: rtl/hsrc_fifo.sv
// Small sample buffer between the input slot rate and the output rate.
// DEPTH must be a power of two; pointers wrap naturally.
module hsrc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_q;
    logic [AW-1:0]    wr_q;
    logic [CW-1:0]    cnt_q;
    logic             wr_ok;
    logic             rd_ok;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign head  = mem[rd_q];
    assign wr_ok = push & ~full;
    assign rd_ok = pop & ~empty;

    // Storage needs no reset: contents are only read while counted.
    always_ff @(posedge clk) begin
        if (clear) begin
            if (push) mem[0] <= din;
        end else if (wr_ok) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            // A clear keeps only the sample pushed in the same cycle.
            rd_q  <= '0;
            wr_q  <= push ? AW'(1) : '0;
            cnt_q <= push ? CW'(1) : '0;
        end else begin
            if (wr_ok) wr_q <= wr_q + 1'b1;
            if (rd_ok) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
        end
    end

endmodule

// File: rtl/hsrc_interp.sv
// Linear interpolation between two samples with a fractional weight,
// rounded half up and clamped to the sample range.
module hsrc_interp #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 8
) (
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    input  logic [FRAC_W-1:0] weight,
    output logic [DATA_W-1:0] result
);
    localparam int PW = DATA_W + FRAC_W + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);
    localparam logic signed [PW-1:0] TOP  = {{(PW-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    logic signed [DATA_W:0] diff;
    logic signed [PW-1:0]   diff_x;
    logic signed [PW-1:0]   wgt_x;
    logic signed [PW-1:0]   left_x;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   biased;
    logic signed [PW-1:0]   delta;
    logic signed [PW-1:0]   total;

    assign diff   = $signed({1'b0, right}) - $signed({1'b0, left});
    assign diff_x = diff;
    assign wgt_x  = {{(PW-FRAC_W){1'b0}}, weight};
    assign left_x = {{(PW-DATA_W){1'b0}}, left};
    assign prod   = diff_x * wgt_x;
    assign biased = prod + HALF;
    assign delta  = biased >>> FRAC_W;
    assign total  = left_x + delta;

    always_comb begin
        if (total < 0)        result = '0;
        else if (total > TOP) result = {DATA_W{1'b1}};
        else                  result = total[DATA_W-1:0];
    end

endmodule

// File: rtl/hsrc_ctrl.sv
// Line controller: slot strobe, line start detection, phase accumulator,
// interpolation window and output register.
module hsrc_ctrl
    import hsrc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FRAC_W    = 8,
    parameter int CODE_W    = 9,
    parameter int STEP_SPAN = 384,
    parameter int CNT_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_we,
    input  logic [CODE_W-1:0] step_code,
    input  logic [CNT_W-1:0]  out_count,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic [DATA_W-1:0] interp_result,
    output logic              in_slot,
    output logic              fifo_clear,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] interp_left,
    output logic [DATA_W-1:0] interp_right,
    output logic [FRAC_W-1:0] interp_weight,
    output logic              out_we,
    output logic [DATA_W-1:0] out_data,
    output hsrc_state_e       state_o,
    output logic              we_prev_o
);
    // Increment per output in 1/2^FRAC_W input samples: BASE (zoom 2)
    // up to BASE + STEP_SPAN (compress 2 when STEP_SPAN = 3*BASE).
    localparam int INC_W = FRAC_W + 2;
    localparam int BASE  = 1 << (FRAC_W - 1);

    hsrc_state_e       state_q, state_d;
    logic              slot_q;
    logic              we_prev_q;
    logic [FRAC_W-1:0] frac_q;
    logic [1:0]        owe_q;      // input samples still to be consumed
    logic              prime_q;
    logic [CNT_W-1:0]  emitted_q;
    logic [DATA_W-1:0] win_a_q;
    logic [DATA_W-1:0] win_b_q;
    logic              out_we_q;
    logic [DATA_W-1:0] out_data_q;

    logic              line_start;
    logic              emit;
    logic              shift;
    logic              use_head;
    logic              last;
    logic [CODE_W-1:0] code_lim;
    logic [INC_W-1:0]  inc;
    logic [INC_W-1:0]  sum;

    assign line_start = slot_q & in_we & ~we_prev_q;
    assign fifo_clear = line_start;
    assign fifo_push  = slot_q & in_we &
                        (line_start | (state_q == ST_PRIME) | (state_q == ST_RUN));

    assign code_lim = (step_code > CODE_W'(STEP_SPAN)) ? CODE_W'(STEP_SPAN) : step_code;
    assign inc      = INC_W'(BASE) + INC_W'(code_lim);
    assign sum      = {2'b00, frac_q} + inc;
    assign last     = ({1'b0, emitted_q} + 1'b1) == {1'b0, out_count};

    assign interp_left   = use_head ? win_b_q : win_a_q;
    assign interp_right  = use_head ? fifo_head : win_b_q;
    assign interp_weight = frac_q;

    // Next state and per-cycle actions.
    always_comb begin
        state_d  = state_q;
        fifo_pop = 1'b0;
        emit     = 1'b0;
        shift    = 1'b0;
        use_head = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PRIME: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    shift    = 1'b1;
                    if (prime_q) state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (owe_q == 2'd0) begin
                    emit = 1'b1;
                end else if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    shift    = 1'b1;
                    if (owe_q == 2'd1) begin
                        emit     = 1'b1;
                        use_head = 1'b1;
                    end
                end
                if (emit && last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (line_start) begin
            state_d  = (out_count == '0) ? ST_IDLE : ST_PRIME;
            fifo_pop = 1'b0;
            emit     = 1'b0;
            shift    = 1'b0;
            use_head = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= 1'b0;
            we_prev_q  <= 1'b0;
            frac_q     <= '0;
            owe_q      <= 2'd0;
            prime_q    <= 1'b0;
            emitted_q  <= '0;
            win_a_q    <= '0;
            win_b_q    <= '0;
            out_we_q   <= 1'b0;
            out_data_q <= '0;
        end else begin
            slot_q   <= ~slot_q;
            if (slot_q) we_prev_q <= in_we;
            out_we_q <= emit;
            if (emit) out_data_q <= interp_result;
            if (shift) begin
                win_a_q <= win_b_q;
                win_b_q <= fifo_head;
            end
            if (line_start) begin
                frac_q    <= '0;
                owe_q     <= 2'd0;
                prime_q   <= 1'b0;
                emitted_q <= '0;
            end else begin
                if (state_q == ST_PRIME && fifo_pop) prime_q <= 1'b1;
                if (state_q == ST_RUN) begin
                    if (emit) begin
                        frac_q    <= sum[FRAC_W-1:0];
                        owe_q     <= sum[INC_W-1:FRAC_W];
                        emitted_q <= emitted_q + 1'b1;
                    end else if (fifo_pop) begin
                        owe_q <= owe_q - 1'b1;
                    end
                end
            end
        end
    end

    assign in_slot   = slot_q;
    assign out_we    = out_we_q;
    assign out_data  = out_data_q;
    assign state_o   = state_q;
    assign we_prev_o = we_prev_q;

endmodule

// File: rtl/hsrc_resampler.sv
module hsrc_resampler
    import hsrc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 8,
    parameter int CODE_W     = 9,
    parameter int STEP_SPAN  = 384,
    parameter int CNT_W      = 11,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_we,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CODE_W-1:0] step_code,
    input  logic [CNT_W-1:0]  out_count,
    output logic              in_slot,
    output logic              out_we,
    output logic [DATA_W-1:0] out_data
);
    logic              fifo_clear;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [DATA_W-1:0] fifo_head;
    logic [DATA_W-1:0] interp_left;
    logic [DATA_W-1:0] interp_right;
    logic [FRAC_W-1:0] interp_weight;
    logic [DATA_W-1:0] interp_result;
    hsrc_state_e       ctrl_state;
    logic              ctrl_we_prev;

    hsrc_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fifo_clear),
        .push  (fifo_push),
        .din   (in_data),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    hsrc_interp #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W)
    ) u_interp (
        .left   (interp_left),
        .right  (interp_right),
        .weight (interp_weight),
        .result (interp_result)
    );

    hsrc_ctrl #(
        .DATA_W    (DATA_W),
        .FRAC_W    (FRAC_W),
        .CODE_W    (CODE_W),
        .STEP_SPAN (STEP_SPAN),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_we         (in_we),
        .step_code     (step_code),
        .out_count     (out_count),
        .fifo_empty    (fifo_empty),
        .fifo_head     (fifo_head),
        .interp_result (interp_result),
        .in_slot       (in_slot),
        .fifo_clear    (fifo_clear),
        .fifo_push     (fifo_push),
        .fifo_pop      (fifo_pop),
        .interp_left   (interp_left),
        .interp_right  (interp_right),
        .interp_weight (interp_weight),
        .out_we        (out_we),
        .out_data      (out_data),
        .state_o       (ctrl_state),
        .we_prev_o     (ctrl_we_prev)
    );

endmodule

// File: rtl/hsrc_checker.sv
module hsrc_checker
    import hsrc_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_slot,
    input logic             in_we,
    input logic             out_we,
    input logic [CNT_W-1:0] out_count,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             fifo_clear,
    input logic             fifo_empty,
    input logic             fifo_full,
    input hsrc_state_e      ctrl_state,
    input logic             ctrl_we_prev
);
    // R7: slot strobe alternates
    a_r7_slot_falls: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |=> !in_slot);
    a_r7_slot_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !in_slot |=> in_slot);

    // R4: no output sample unless the controller was producing
    a_r4_quiet_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state != ST_RUN) |=> !out_we);

    // R5: a line start with a nonzero count enters the priming state
    a_r5_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && in_we && !ctrl_we_prev && out_count != '0) |=> (ctrl_state == ST_PRIME));

    // R6: a zero count line stays idle
    a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && in_we && !ctrl_we_prev && out_count == '0) |=> (ctrl_state == ST_IDLE));

    // R9: buffer never overflows or underflows
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !fifo_clear) |-> !fifo_full);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

endmodule

bind hsrc_resampler hsrc_checker #(.CNT_W(CNT_W)) i_hsrc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_slot      (in_slot),
    .in_we        (in_we),
    .out_we       (out_we),
    .out_count    (out_count),
    .fifo_push    (fifo_push),
    .fifo_pop     (fifo_pop),
    .fifo_clear   (fifo_clear),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .ctrl_state   (ctrl_state),
    .ctrl_we_prev (ctrl_we_prev)
);

// File: tb/test_hsrc_resampler.sv
`timescale 1ns/1ps
module test_hsrc_resampler;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_we;
    logic [7:0]  in_data;
    logic [8:0]  step_code;
    logic [10:0] out_count;
    logic        in_slot;
    logic        out_we;
    logic [7:0]  out_data;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    seen = 0;
    int    first_cyc = 0;
    int    last_cyc = 0;
    int    exp_val;
    string cur_tag = "R4";
    int    exp_q[$];
    bit    done = 1'b0;

    always #5 clk = ~clk;

    hsrc_resampler i_hsrc_resampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_we     (in_we),
        .in_data   (in_data),
        .step_code (step_code),
        .out_count (out_count),
        .in_slot   (in_slot),
        .out_we    (out_we),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected samples as the design produces them.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && out_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s R4: unexpected output actual %0d expected none", cur_tag, out_data);
            end else begin
                exp_val = exp_q.pop_front();
                if (int'(out_data) != exp_val) begin
                    errors++;
                    $display("FAIL %s R3: output actual %0d expected %0d", cur_tag, out_data, exp_val);
                end
            end
            if (seen == 0) first_cyc = cyc;
            last_cyc = cyc;
            seen++;
        end
    end

    function automatic int pat_val(input int pat, input int j);
        case (pat)
            0:       return (j * 13 + 7) % 256;
            1:       return (j % 2 == 0) ? 0 : 255;
            default: return (j * 37 + 90) % 256;
        endcase
    endfunction

    task automatic wait_slot();
        do @(negedge clk); while (!in_slot);
    endtask

    // Driver: computes the expected line, queues it, then drives the input.
    task automatic run_line(input int n_in, input int n_out, input int code,
                            input int pat, input string tag, output int n_exp);
        int s[64];
        int inc;
        inc = 128 + ((code > 384) ? 384 : code);
        for (int j = 0; j < n_in; j++) s[j] = pat_val(pat, j);
        n_exp = 0;
        for (int k = 0; k < n_out; k++) begin
            int p = k * inc;
            int i = p >>> 8;
            int f = p & 255;
            int t;
            int y;
            if (i + 1 >= n_in) break;
            t = (s[i+1] - s[i]) * f + 128;
            y = s[i] + (t >>> 8);
            if (y < 0) y = 0;
            if (y > 255) y = 255;
            exp_q.push_back(y);
            n_exp++;
        end
        @(negedge clk);
        cur_tag   = tag;
        seen      = 0;
        step_code = 9'(code);
        out_count = 11'(n_out);
        for (int j = 0; j < n_in; j++) begin
            wait_slot();
            in_we   = 1'b1;
            in_data = 8'(s[j]);
        end
        wait_slot();
        in_we = 1'b0;
    endtask

    task automatic finish_line(input string tag, input int n_exp);
        repeat (60) @(negedge clk);
        check(exp_q.size() == 0, {tag, " R6 missing outputs"}, exp_q.size(), 0);
        check(seen == n_exp, {tag, " R6 output count"}, seen, n_exp);
        exp_q.delete();
    endtask

    initial begin
        int n;
        rst_n     = 1'b0;
        in_we     = 1'b0;
        in_data   = 8'd0;
        step_code = 9'd0;
        out_count = 11'd0;
        repeat (3) @(negedge clk);
        check(out_we == 1'b0, "R1 out_we in reset", out_we, 0);
        rst_n = 1'b1;
        check(out_we == 1'b0 && out_data == 8'd0, "R1 outputs after reset", out_data, 0);
        check(in_slot == 1'b0, "R7 slot after reset", in_slot, 0);
        @(negedge clk);
        check(in_slot == 1'b1, "R7 slot toggles high", in_slot, 1);
        @(negedge clk);
        check(in_slot == 1'b0, "R7 slot toggles low", in_slot, 0);

        // R8: zoom by two, sustained output every cycle
        run_line(12, 16, 0, 2, "R8", n);
        finish_line("R8", n);
        check(last_cyc - first_cyc + 1 == 16, "R8 outputs on consecutive cycles",
              last_cyc - first_cyc + 1, 16);

        // R9: compress by two at full input rate
        run_line(24, 10, 384, 0, "R9", n);
        finish_line("R9", n);

        // R3: fractional step with varying weights
        run_line(22, 20, 100, 2, "R3", n);
        finish_line("R3", n);

        // R3: rounding toward half on alternating extremes
        run_line(10, 12, 0, 1, "R3", n);
        finish_line("R3", n);

        // R2: code above the span behaves as the compress limit
        run_line(20, 8, 500, 0, "R2", n);
        finish_line("R2", n);
        run_line(20, 8, 256, 2, "R2", n);
        finish_line("R2", n);

        // R6: zero count gives no output
        run_line(8, 0, 256, 0, "R6", n);
        finish_line("R6", n);
        check(seen == 0, "R6 zero count silent", seen, 0);

        // R5: short line stalls, then a new line restarts cleanly
        run_line(5, 40, 0, 0, "R5", n);
        finish_line("R5", n);
        check(n == 8, "R5 abandoned line outputs", n, 8);
        run_line(20, 10, 200, 2, "R5", n);
        finish_line("R5", n);

        // R6: surplus input after the count is ignored
        run_line(30, 5, 0, 2, "R6", n);
        finish_line("R6", n);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule